// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Controller

This block connects a row of interrupting device slots to one processor interrupt line. Each slot holds a pending flag that a one-cycle request pulse sets. The processor sees a single request, which is the OR of all pending flags and is gated by a global enable. When the processor raises its acknowledge, the acknowledge enters the chain at slot 0. Each slot that has nothing pending passes it on combinationally. The first slot that has a pending request keeps the acknowledge and blocks it from going further down the chain.

The winning slot answers with its own programmable vector on the data output and withdraws its request. Priority therefore comes only from position in the chain. The processor can use the returned vector directly as the pointer to a service routine, so no software scan of the devices is needed. The controller does no context saving and runs no service routine.

Top module: `irq_chain_ctrl`

## Requirements
- R1: After reset `irq_o` is low, `vec_o` is zero and no slot is pending.
- R2: A one-cycle pulse on `slot_req_i[k]` sets the pending flag of slot k. While `irq_en_i` is high, `irq_o` is high in the cycle after the pulse and stays high as long as any slot is pending.
- R3: While `irq_en_i` is low, `irq_o` stays low. Pending flags are kept and are reported again once the enable returns.
- R4: An acknowledge is taken on a rising edge of `ack_i`. The pending slot with the lowest index wins. Its vector appears on `vec_o` in the cycle after the rise.
- R5: The winning slot's pending flag is cleared. The other pending flags stay set and are served by later acknowledges in index order.
- R6: If no slot is pending when `ack_i` rises, `vec_o` is zero in the following cycle.
- R7: While `ack_i` stays high, `vec_o` holds its value and no further slot is granted. `vec_o` returns to zero one cycle after `ack_i` is sampled low.
- R8: A request pulse in the same cycle as an acknowledge rise does not take part in that acknowledge. It stays pending for the next acknowledge.
- R9: If a request pulse for the winning slot arrives in the same cycle as its grant, that slot remains pending.
- R10: An acknowledge grants at most one slot.
- R11: The vector of slot k is read from `slot_vec_i[k*VEC_W +: VEC_W]` in the acknowledge cycle, so a reprogrammed vector takes effect on the next acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_en_i | input | 1 | Global interrupt enable |
| slot_req_i | input | N_SLOTS | Per-slot request pulses |
| slot_vec_i | input | N_SLOTS*VEC_W | Per-slot vectors, slot k at bits k*VEC_W upward |
| ack_i | input | 1 | Processor acknowledge |
| irq_o | output | 1 | Shared interrupt request to the processor |
| vec_o | output | VEC_W | Vector of the acknowledged slot, zero otherwise |

## Verification
The bench targets the priority order when several slots are pending together. A chain that scanned from the wrong end, or that failed to clear the winner, would return vectors in the wrong order or return the same vector twice. It also holds the acknowledge high for several cycles; a design that acted on the level instead of the edge would drain further slots during that time. It pulses requests in the same cycle as an acknowledge rise, both for another slot and for the winning slot itself. A design that let late requests join the chain would answer with the wrong vector, and one that gave clear priority over set would lose an interrupt. It also checks that the enable masks only the request line without discarding pending flags, and that an acknowledge with nothing pending yields a zero vector.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  parameter int unsigned DEF_SLOTS = 4;
  parameter int unsigned DEF_VEC_W = 8;
endpackage

// File: rtl/irq_chain_slot.sv
module irq_chain_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic ack_in_i,
  output logic ack_out_o,
  output logic grant_o,
  output logic pending_o
);
  logic pend_q;

  assign grant_o   = ack_in_i & pend_q;
  assign ack_out_o = ack_in_i & ~pend_q;
  assign pending_o = pend_q;

  // set wins over clear so a coincident request is not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q & ~grant_o) | req_i;
  end
endmodule

// File: rtl/irq_chain_vec_sel.sv
module irq_chain_vec_sel #(
  parameter int unsigned N_SLOTS = 4,
  parameter int unsigned VEC_W   = 8
) (
  input  logic [N_SLOTS-1:0]       grant_i,
  input  logic [N_SLOTS*VEC_W-1:0] vec_i,
  output logic [VEC_W-1:0]         vec_o
);
  always_comb begin
    vec_o = '0;
    for (int k = 0; k < N_SLOTS; k++) begin
      if (grant_i[k]) vec_o = vec_o | vec_i[k*VEC_W +: VEC_W];
    end
  end
endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl #(
  parameter int unsigned N_SLOTS = irq_chain_pkg::DEF_SLOTS,
  parameter int unsigned VEC_W   = irq_chain_pkg::DEF_VEC_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     irq_en_i,
  input  logic [N_SLOTS-1:0]       slot_req_i,
  input  logic [N_SLOTS*VEC_W-1:0] slot_vec_i,
  input  logic                     ack_i,
  output logic                     irq_o,
  output logic [VEC_W-1:0]         vec_o
);
  localparam int unsigned CHAIN_W = N_SLOTS + 1;

  logic               ack_q;
  logic               ack_rise;
  logic [CHAIN_W-1:0] chain;
  logic [N_SLOTS-1:0] grant;
  logic [N_SLOTS-1:0] pending;
  logic [VEC_W-1:0]   vec_sel;
  logic [VEC_W-1:0]   vec_q;

  assign ack_rise = ack_i & ~ack_q;
  assign chain[0] = ack_rise;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    irq_chain_slot u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (slot_req_i[g]),
      .ack_in_i  (chain[g]),
      .ack_out_o (chain[g+1]),
      .grant_o   (grant[g]),
      .pending_o (pending[g])
    );
  end

  irq_chain_vec_sel #(.N_SLOTS(N_SLOTS), .VEC_W(VEC_W)) u_sel (
    .grant_i (grant),
    .vec_i   (slot_vec_i),
    .vec_o   (vec_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      vec_q <= '0;
    end else begin
      ack_q <= ack_i;
      if (!ack_i)       vec_q <= '0;
      else if (ack_rise) vec_q <= vec_sel;
    end
  end

  assign irq_o = irq_en_i & (|pending);
  assign vec_o = vec_q;
endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
  parameter int unsigned N_SLOTS = 4,
  parameter int unsigned VEC_W   = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               irq_en_i,
  input logic               ack_i,
  input logic               ack_q,
  input logic [N_SLOTS-1:0] slot_req_i,
  input logic [N_SLOTS-1:0] pending,
  input logic [N_SLOTS-1:0] grant,
  input logic               irq_o,
  input logic [VEC_W-1:0]   vec_o
);
  assert_irq_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);

  assert_irq_pending_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i && (|pending)) |-> irq_o);

  assert_one_grant_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));

  assert_edge_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |-> (grant == '0));

  assert_empty_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !ack_q && (pending == '0)) |=> (vec_o == '0));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_q) |=> $stable(vec_o));

  assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> (vec_o == '0));

  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grant != '0) && ((grant & slot_req_i) == '0)) |=> ((pending & $past(grant)) == '0));
endmodule

bind irq_chain_ctrl irq_chain_chk #(.N_SLOTS(N_SLOTS), .VEC_W(VEC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_en_i   (irq_en_i),
  .ack_i      (ack_i),
  .ack_q      (ack_q),
  .slot_req_i (slot_req_i),
  .pending    (pending),
  .grant      (grant),
  .irq_o      (irq_o),
  .vec_o      (vec_o)
);

// File: tb/sim_irq_chain_ctrl.sv
module sim_irq_chain_ctrl;
  localparam int unsigned NS = 4;
  localparam int unsigned VW = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             irq_en = 1'b1;
  logic [NS-1:0]    req = '0;
  logic [NS*VW-1:0] vecs;
  logic             ack = 1'b0;
  logic             irq;
  logic [VW-1:0]    vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_chain_ctrl #(.N_SLOTS(NS), .VEC_W(VW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_en_i(irq_en), .slot_req_i(req),
    .slot_vec_i(vecs), .ack_i(ack), .irq_o(irq), .vec_o(vec)
  );

  function automatic logic [VW-1:0] vec_of(int k);
    return 8'h15 + 8'(k * 16);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic post(logic [NS-1:0] m);
    @(negedge clk); req = m;
    @(negedge clk); req = '0;
  endtask

  // rise ack, sample vector next cycle, drop ack, confirm vector clears
  task automatic ack_once(string tag, logic [VW-1:0] exp);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); chk(tag, vec, exp); ack = 1'b0;
    @(negedge clk); chk("R7 idle", vec, 0);
  endtask

  // [7:4] posted mask, [3:0] index of first winner (15 = none)
  localparam logic [7:0] TBL [8] = '{
    8'h10, 8'h21, 8'h83, 8'h61, 8'hF0, 8'hC2, 8'hA1, 8'h0F
  };

  initial begin
    for (int k = 0; k < NS; k++) vecs[k*VW +: VW] = vec_of(k);
    #10;
    chk("R1 irq", irq, 0);
    chk("R1 vec", vec, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after", irq, 0);

    for (int i = 0; i < 8; i++) begin
      logic [NS-1:0] m;
      bit first;
      m = TBL[i][7:4];
      first = 1'b1;
      post(m);
      chk("R2 irq", irq, m != 0);
      for (int k = 0; k < NS; k++) begin
        if (m[k]) begin
          if (first) chk("R4 first idx", k, TBL[i][3:0]);
          first = 1'b0;
          ack_once("R4 R5 vec", vec_of(k));
        end
      end
      chk("R5 drained", irq, 0);
      ack_once("R6 empty", 0);
    end

    // R3 masking keeps pending
    irq_en = 1'b0;
    post(4'b0100);
    chk("R3 masked", irq, 0);
    @(negedge clk); irq_en = 1'b1;
    #1 chk("R3 restored", irq, 1);
    ack_once("R3 vec", vec_of(2));

    // R8 request during acknowledge rise
    post(4'b0100);
    @(negedge clk); ack = 1'b1; req = 4'b0001;
    @(negedge clk); req = '0; chk("R8 winner", vec, vec_of(2)); ack = 1'b0;
    @(negedge clk);
    chk("R8 still pending", irq, 1);
    ack_once("R8 next", vec_of(0));

    // R7 held acknowledge
    post(4'b1010);
    @(negedge clk); ack = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); chk("R7 hold", vec, vec_of(1));
    end
    chk("R7 no second grant", irq, 1);
    ack = 1'b0;
    @(negedge clk); chk("R7 clear", vec, 0);
    ack_once("R7 next", vec_of(3));
    chk("R7 drained", irq, 0);

    // R9 request coinciding with own grant
    post(4'b0010);
    @(negedge clk); ack = 1'b1; req = 4'b0010;
    @(negedge clk); req = '0; chk("R9 vec", vec, vec_of(1)); ack = 1'b0;
    @(negedge clk); chk("R9 kept", irq, 1);
    ack_once("R9 again", vec_of(1));

    // R11 reprogrammed vector
    vecs[3*VW +: VW] = 8'hC7;
    post(4'b1000);
    ack_once("R11 new vec", 8'hC7);

    // R1 reset clears pending
    post(4'b0011);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); chk("R1 reset irq", irq, 0); rst_n = 1'b1;
    ack_once("R1 nothing pending", 0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule